// File: doc/BRIEF.md
# Flash Toggle-Bit Status Generator

This block produces the status read path of a parallel NOR flash while an embedded program or erase runs. It takes start, suspend, resume and reset command events and keeps an operation state internally: idle, programming, erasing, erase-suspended, or programming inside an erase suspend. Each embedded operation is timed by a parameterised cycle counter. There is no real cell algorithm.

A read cycle starts when the output-enable and chip-enable strobes are both low, and either strobe may be the one that falls last. A busy device answers every read with a status word. Bit 6 of that word inverts on each read at any address. Bit 2 inverts only when the read falls in a sector that is selected for erase. Used together, the two bits tell an active erase apart from a suspended one, and they show which sectors the erase covers. When a program targets a protected sector, or when every selected erase sector is protected, the erase or program is replaced by a short busy burst. The device then returns to array reads. A ready output and a one-cycle completion pulse finish the interface.

Top module: `flash_toggle_status`

## Requirements
- R1: Reset and idle behaviour. While `rst` is high, the block goes to idle with `rdy`=1, `op_done`=0 and both toggle bits at 0. In idle, `dq_out` equals `arr_data`.
- R2: A read start is the first cycle in which `oe_n` and `ce_n` are both low, in either falling order. In the program, erase and suspend-program states, each read start inverts bit 6 of `dq_out`. Every read then returns a status word whose only nonzero bits are bit 6 and bit 2.
- R3: `rdy` is 0 in the program, erase and suspend-program states. It is 1 in idle and in erase suspend.
- R4: Timing and completion. An unprotected program is busy for exactly PGM_CYC cycles, and an erase is busy for exactly ERS_CYC cycles. When either ends, `op_done` pulses high for one cycle, at the same time as `rdy` returns high.
- R5: A program whose target sector (the top log2(N_SECT) address bits) has its `prot_mask` bit set is busy for CLK_MHZ cycles, which is 1 µs. Bit 6 toggles during this burst. The device then returns to array reads.
- R6: Erase and protection. If every sector in `cmd_sel` is protected, the erase becomes a burst of 100×CLK_MHZ cycles, and all selected sectors count as erase-selected. If only some are protected, the erase lasts ERS_CYC cycles and the protected sectors are left out of the erase-selected set.
- R7: Bit 2 inverts on a read start only when the state is erase, erase suspend or suspend-program and the read sector is erase-selected. Otherwise it holds its value.
- R8: A suspend command accepted during erase enters erase suspend with `rdy`=1. In that state bit 6 stops toggling. Reads of erase-selected sectors return the status word, and reads of other sectors return `arr_data`. A resume command continues the erase, so the erase-busy cycles before and after the suspend add up to ERS_CYC.
- R9: A program command in erase suspend makes the block busy and bit 6 toggles. When the program ends, `op_done` pulses and the block returns to erase suspend, not to idle.
- R10: A reset command forces idle at the next edge from any state, with no `op_done` pulse. Commands that do not fit the current state are ignored: suspend or resume in idle, an erase with an empty `cmd_sel`, and a program issued while a program is already running.
- R11: A read that holds both strobes low for many cycles inverts each toggle bit only once, and both bits hold their value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command event strobe, one cycle |
| cmd_code | input | 3 | 1 program, 2 erase, 3 suspend, 4 resume, 5 reset |
| cmd_addr | input | ADDR_W | Program target address |
| cmd_sel | input | N_SECT | Sectors selected for erase |
| prot_mask | input | N_SECT | Per-sector protection |
| rd_addr | input | ADDR_W | Read address |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| arr_data | input | DATA_W | Array data returned in array-read mode |
| dq_out | output | DATA_W | Read data or status word |
| rdy | output | 1 | Ready (1) / busy (0) |
| op_done | output | 1 | One-cycle pulse at end of an embedded operation |

## Verification
A table drives programs and erases with no protection, partial protection and full protection. Each case separates the four possible busy lengths and the completion pulse. Reads are tried with output-enable falling last, with chip-enable falling last, and with a long held strobe. They are made to erase-selected sectors, to protected selected sectors and to unselected sectors. This shows whether bit 6, bit 2 or neither moves. The suspend, suspend-program and resume sequence separates erase suspend from idle through which sectors still return status, and it checks that the busy cycles before and after the suspend add up to the full erase time.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PGM   = 3'd1,
        ST_ERS   = 3'd2,
        ST_ESUSP = 3'd3,
        ST_ESPGM = 3'd4
    } op_state_e;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PGM  = 3'd1,
        CMD_ERS  = 3'd2,
        CMD_SUSP = 3'd3,
        CMD_RES  = 3'd4,
        CMD_RST  = 3'd5
    } cmd_e;

    typedef struct packed {
        logic t6;
        logic t2;
    } tog_t;

    localparam int TOG_HI_POS = 6;
    localparam int TOG_LO_POS = 2;

    // Embedded algorithm running: status on every read, ready low.
    function automatic logic st_busy(op_state_e s);
        return (s == ST_PGM) || (s == ST_ERS) || (s == ST_ESPGM);
    endfunction

    // An erase is in progress or suspended: sector toggle is live.
    function automatic logic st_erase_live(op_state_e s);
        return (s == ST_ERS) || (s == ST_ESUSP) || (s == ST_ESPGM);
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tbs_ctrl.sv
module tbs_ctrl
    import tbs_pkg::*;
#(
    parameter int N_SECT  = 8,
    parameter int SECT_W  = 3,
    parameter int PGM_CYC = 20,
    parameter int ERS_CYC = 200,
    parameter int PP_CYC  = 10,
    parameter int PE_CYC  = 1000,
    parameter int CNT_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [SECT_W-1:0] cmd_sect,
    input  logic [N_SECT-1:0] cmd_sel,
    input  logic [N_SECT-1:0] prot_mask,
    output op_state_e         state,
    output logic [N_SECT-1:0] ers_mask,
    output logic              op_done
);

    localparam logic [CNT_W-1:0] PGM_LD = CNT_W'(PGM_CYC - 1);
    localparam logic [CNT_W-1:0] ERS_LD = CNT_W'(ERS_CYC - 1);
    localparam logic [CNT_W-1:0] PP_LD  = CNT_W'(PP_CYC - 1);
    localparam logic [CNT_W-1:0] PE_LD  = CNT_W'(PE_CYC - 1);

    cmd_e             cmd;
    logic [CNT_W-1:0] pgm_cnt;
    logic [CNT_W-1:0] ers_cnt;
    logic             tgt_prot;
    logic             all_prot;
    logic             is_pgm, is_ers, is_susp, is_res, is_rst;

    assign cmd      = cmd_e'(cmd_code);
    assign is_pgm   = cmd_valid && (cmd == CMD_PGM);
    assign is_ers   = cmd_valid && (cmd == CMD_ERS) && (|cmd_sel);
    assign is_susp  = cmd_valid && (cmd == CMD_SUSP);
    assign is_res   = cmd_valid && (cmd == CMD_RES);
    assign is_rst   = cmd_valid && (cmd == CMD_RST);
    assign tgt_prot = prot_mask[cmd_sect];
    // every selected sector is also protected
    assign all_prot = &(~cmd_sel | prot_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pgm_cnt  <= '0;
            ers_cnt  <= '0;
            ers_mask <= '0;
            op_done  <= 1'b0;
        end else begin
            op_done <= 1'b0;
            if (is_rst) begin
                state    <= ST_IDLE;
                pgm_cnt  <= '0;
                ers_cnt  <= '0;
                ers_mask <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (is_pgm) begin
                            state   <= ST_PGM;
                            pgm_cnt <= tgt_prot ? PP_LD : PGM_LD;
                        end else if (is_ers) begin
                            state <= ST_ERS;
                            if (all_prot) begin
                                ers_cnt  <= PE_LD;
                                ers_mask <= cmd_sel;
                            end else begin
                                ers_cnt  <= ERS_LD;
                                ers_mask <= cmd_sel & ~prot_mask;
                            end
                        end
                    end
                    ST_PGM: begin
                        if (pgm_cnt == '0) begin
                            state   <= ST_IDLE;
                            op_done <= 1'b1;
                        end else begin
                            pgm_cnt <= pgm_cnt - 1'b1;
                        end
                    end
                    ST_ERS: begin
                        if (ers_cnt == '0) begin
                            state    <= ST_IDLE;
                            op_done  <= 1'b1;
                            ers_mask <= '0;
                        end else begin
                            ers_cnt <= ers_cnt - 1'b1;
                            if (is_susp) state <= ST_ESUSP;
                        end
                    end
                    ST_ESUSP: begin
                        if (is_res) begin
                            state <= ST_ERS;
                        end else if (is_pgm) begin
                            state   <= ST_ESPGM;
                            pgm_cnt <= tgt_prot ? PP_LD : PGM_LD;
                        end
                    end
                    ST_ESPGM: begin
                        if (pgm_cnt == '0) begin
                            state   <= ST_ESUSP;
                            op_done <= 1'b1;
                        end else begin
                            pgm_cnt <= pgm_cnt - 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/tbs_toggle.sv
module tbs_toggle
    import tbs_pkg::*;
#(
    parameter int N_SECT = 8,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  op_state_e         state,
    input  logic [N_SECT-1:0] ers_mask,
    input  logic [SECT_W-1:0] rd_sect,
    input  logic              oe_n,
    input  logic              ce_n,
    output tog_t              tog
);

    logic rd_act;
    logic rd_q;
    logic rd_start;

    assign rd_act   = ~oe_n & ~ce_n;
    assign rd_start = rd_act & ~rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            tog  <= '0;
        end else begin
            rd_q <= rd_act;
            if (rd_start && st_busy(state))
                tog.t6 <= ~tog.t6;
            if (rd_start && st_erase_live(state) && ers_mask[rd_sect])
                tog.t2 <= ~tog.t2;
        end
    end

endmodule

// File: rtl/tbs_outmux.sv
module tbs_outmux
    import tbs_pkg::*;
#(
    parameter int N_SECT = 8,
    parameter int SECT_W = 3,
    parameter int DATA_W = 8
) (
    input  op_state_e         state,
    input  logic [N_SECT-1:0] ers_mask,
    input  logic [SECT_W-1:0] rd_sect,
    input  tog_t              tog,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dq_out
);

    logic [DATA_W-1:0] stat_word;
    logic              show_stat;

    always_comb begin
        stat_word             = '0;
        stat_word[TOG_HI_POS] = tog.t6;
        stat_word[TOG_LO_POS] = tog.t2;
    end

    assign show_stat = st_busy(state) ||
                       ((state == ST_ESUSP) && ers_mask[rd_sect]);
    assign dq_out    = show_stat ? stat_word : arr_data;

endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status
    import tbs_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 10,
    parameter int N_SECT  = 8,
    parameter int CLK_MHZ = 10,
    parameter int PGM_CYC = 20,
    parameter int ERS_CYC = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [N_SECT-1:0] cmd_sel,
    input  logic [N_SECT-1:0] prot_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              oe_n,
    input  logic              ce_n,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              rdy,
    output logic              op_done
);

    localparam int SECT_W = $clog2(N_SECT);
    localparam int PP_CYC = CLK_MHZ;        // 1 us burst
    localparam int PE_CYC = 100 * CLK_MHZ;  // 100 us burst
    localparam int MAXC   = max2(max2(PGM_CYC, ERS_CYC), max2(PP_CYC, PE_CYC));
    localparam int CNT_W  = $clog2(MAXC + 1);

    op_state_e         state;
    logic [N_SECT-1:0] ers_mask;
    tog_t              tog;
    logic [SECT_W-1:0] cmd_sect;
    logic [SECT_W-1:0] rd_sect;
    logic              unused_low;

    assign cmd_sect   = cmd_addr[ADDR_W-1 -: SECT_W];
    assign rd_sect    = rd_addr[ADDR_W-1 -: SECT_W];
    assign unused_low = ^{cmd_addr[ADDR_W-SECT_W-1:0], rd_addr[ADDR_W-SECT_W-1:0]};

    tbs_ctrl #(
        .N_SECT (N_SECT),
        .SECT_W (SECT_W),
        .PGM_CYC(PGM_CYC),
        .ERS_CYC(ERS_CYC),
        .PP_CYC (PP_CYC),
        .PE_CYC (PE_CYC),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_code (cmd_code),
        .cmd_sect (cmd_sect),
        .cmd_sel  (cmd_sel),
        .prot_mask(prot_mask),
        .state    (state),
        .ers_mask (ers_mask),
        .op_done  (op_done)
    );

    tbs_toggle #(
        .N_SECT(N_SECT),
        .SECT_W(SECT_W)
    ) u_toggle (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .ers_mask(ers_mask),
        .rd_sect (rd_sect),
        .oe_n    (oe_n),
        .ce_n    (ce_n),
        .tog     (tog)
    );

    tbs_outmux #(
        .N_SECT(N_SECT),
        .SECT_W(SECT_W),
        .DATA_W(DATA_W)
    ) u_outmux (
        .state   (state),
        .ers_mask(ers_mask),
        .rd_sect (rd_sect),
        .tog     (tog),
        .arr_data(arr_data),
        .dq_out  (dq_out)
    );

    assign rdy = ~st_busy(state);

endmodule

// File: rtl/tbs_checker.sv
module tbs_checker
    import tbs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              oe_n,
    input logic              ce_n,
    input logic [DATA_W-1:0] arr_data,
    input logic [DATA_W-1:0] dq_out,
    input logic              rdy,
    input logic              op_done,
    input op_state_e         state,
    input tog_t              tog
);

    localparam logic [DATA_W-1:0] STAT_BITS =
        (DATA_W'(1) << TOG_HI_POS) | (DATA_W'(1) << TOG_LO_POS);

    assert_idle_array_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (dq_out == arr_data));

    assert_busy_word_R2: assert property (@(posedge clk) disable iff (rst)
        !rdy |-> ((dq_out & ~STAT_BITS) == '0));

    assert_done_ready_R4: assert property (@(posedge clk) disable iff (rst)
        op_done |-> rdy);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done);

    assert_dq2_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) || (state == ST_PGM)) |=> $stable(tog.t2));

    assert_susp_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ESUSP) |=> $stable(tog.t6));

    assert_no_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (oe_n || ce_n) |=> $stable(tog));

endmodule

bind flash_toggle_status tbs_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .oe_n    (oe_n),
    .ce_n    (ce_n),
    .arr_data(arr_data),
    .dq_out  (dq_out),
    .rdy     (rdy),
    .op_done (op_done),
    .state   (state),
    .tog     (tog)
);

// File: tb/flash_toggle_status_test.sv
module flash_toggle_status_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 10;
    localparam int N_SECT  = 8;
    localparam int CLK_MHZ = 4;
    localparam int PGM_C   = 12;
    localparam int ERS_C   = 60;
    localparam int PP_C    = CLK_MHZ;
    localparam int PE_C    = 100 * CLK_MHZ;
    localparam logic [7:0] ARR = 8'hA5;

    typedef struct packed {
        logic [2:0] code;
        logic [2:0] sect;
        logic [7:0] sel;
        logic [7:0] prot;
        int         len;
    } vec_t;

    // R4 R5 R6: busy length per operation and protection pattern
    localparam vec_t VEC [5] = '{
        '{code: 3'd1, sect: 3'd3, sel: 8'h00, prot: 8'h00, len: PGM_C},
        '{code: 3'd1, sect: 3'd3, sel: 8'h00, prot: 8'h08, len: PP_C},
        '{code: 3'd2, sect: 3'd0, sel: 8'h0C, prot: 8'h04, len: ERS_C},
        '{code: 3'd2, sect: 3'd0, sel: 8'h0C, prot: 8'h0C, len: PE_C},
        '{code: 3'd2, sect: 3'd0, sel: 8'hFF, prot: 8'h00, len: ERS_C}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_code = 3'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [N_SECT-1:0] cmd_sel = '0;
    logic [N_SECT-1:0] prot_mask = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              oe_n = 1'b1;
    logic              ce_n = 1'b1;
    logic [DATA_W-1:0] arr_data = ARR;
    logic [DATA_W-1:0] dq_out;
    logic              rdy;
    logic              op_done;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  ncyc    = 0;
    int  wd      = 0;
    bit  ended   = 0;
    logic exp6 = 1'b0;
    logic exp2 = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_toggle_status #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .N_SECT (N_SECT),
        .CLK_MHZ(CLK_MHZ),
        .PGM_CYC(PGM_C),
        .ERS_CYC(ERS_C)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_code (cmd_code),
        .cmd_addr (cmd_addr),
        .cmd_sel  (cmd_sel),
        .prot_mask(prot_mask),
        .rd_addr  (rd_addr),
        .oe_n     (oe_n),
        .ce_n     (ce_n),
        .arr_data (arr_data),
        .dq_out   (dq_out),
        .rdy      (rdy),
        .op_done  (op_done)
    );

    function automatic logic [ADDR_W-1:0] sa(int s);
        return ADDR_W'(s) << (ADDR_W - 3);
    endfunction

    function automatic logic [7:0] stat_word();
        return {1'b0, exp6, 3'b000, exp2, 2'b00};
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        ncyc++;
    endtask

    task automatic send(logic [2:0] code, int sect, logic [7:0] sel, logic [7:0] prot);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_addr  = sa(sect);
        cmd_sel   = sel;
        prot_mask = prot;
        tick();
        cmd_valid = 1'b0;
        cmd_code  = 3'd0;
    endtask

    task automatic do_read(int sect, bit ce_last, int hold, output logic [7:0] d);
        rd_addr = sa(sect);
        if (ce_last) oe_n = 1'b0; else ce_n = 1'b0;
        tick();
        if (ce_last) ce_n = 1'b0; else oe_n = 1'b0;
        for (int i = 0; i < hold; i++) tick();
        d    = dq_out;
        oe_n = 1'b1;
        ce_n = 1'b1;
        tick();
    endtask

    task automatic wait_ready(int maxc, output int cnt, output logic done_seen);
        cnt = 0;
        while (!rdy && cnt < maxc) begin
            cnt++;
            tick();
        end
        done_seen = op_done;
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000 && !ended) begin
            ended = 1;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", wd);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int         cnt;
        int         t0;
        int         p1;
        logic       dn;

        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        check("R1 rdy", int'(rdy), 1);
        check("R1 done", int'(op_done), 0);
        check("R1 idle data", int'(dq_out), int'(ARR));

        // table walk: busy length and done pulse
        for (int k = 0; k < 5; k++) begin
            send(VEC[k].code, int'(VEC[k].sect), VEC[k].sel, VEC[k].prot);
            check("R3 busy after start", int'(rdy), 0);
            wait_ready(VEC[k].len + 20, cnt, dn);
            check("R4 R5 R6 busy length", cnt, VEC[k].len);
            check("R4 done pulse", int'(dn), 1);
            tick();
            check("R4 done single", int'(op_done), 0);
            do_read(int'(VEC[k].sect), 1'b0, 2, d);
            check("R5 R6 array after op", int'(d), int'(ARR));
        end

        // R2: program, read with oe last then ce last
        send(3'd1, 2, 8'h00, 8'h00);
        do_read(6, 1'b0, 2, d);
        exp6 = ~exp6;
        check("R2 dq6 read oe-last", int'(d), int'(stat_word()));
        do_read(6, 1'b1, 2, d);
        exp6 = ~exp6;
        check("R2 dq6 read ce-last", int'(d), int'(stat_word()));
        wait_ready(PGM_C + 5, cnt, dn);
        do_read(6, 1'b0, 2, d);
        check("R2 stops after program", int'(d), int'(ARR));

        // R7 R11 R8 R9: erase sectors 1,2
        send(3'd2, 0, 8'h06, 8'h00);
        t0 = ncyc;
        do_read(1, 1'b0, 2, d);
        exp6 = ~exp6; exp2 = ~exp2;
        check("R7 dq2 selected sector", int'(d), int'(stat_word()));
        do_read(5, 1'b1, 2, d);
        exp6 = ~exp6;
        check("R7 dq2 holds unselected", int'(d), int'(stat_word()));
        do_read(2, 1'b0, 7, d);
        exp6 = ~exp6; exp2 = ~exp2;
        check("R11 long read one toggle", int'(d), int'(stat_word()));
        p1 = ncyc - t0 + 1;
        send(3'd3, 0, 8'h00, 8'h00);
        check("R8 R3 ready in suspend", int'(rdy), 1);
        do_read(1, 1'b0, 2, d);
        exp2 = ~exp2;
        check("R8 suspend dq6 still dq2 toggles", int'(d), int'(stat_word()));
        do_read(5, 1'b0, 2, d);
        check("R8 unselected returns array", int'(d), int'(ARR));
        send(3'd1, 5, 8'h00, 8'h00);
        check("R9 busy in suspend program", int'(rdy), 0);
        do_read(5, 1'b1, 2, d);
        exp6 = ~exp6;
        check("R9 dq6 toggles in suspend program", int'(d), int'(stat_word()));
        wait_ready(PGM_C + 5, cnt, dn);
        check("R9 done pulse", int'(dn), 1);
        do_read(1, 1'b0, 2, d);
        exp2 = ~exp2;
        check("R9 back in suspend", int'(d), int'(stat_word()));
        send(3'd4, 0, 8'h00, 8'h00);
        check("R8 busy after resume", int'(rdy), 0);
        wait_ready(ERS_C + 5, cnt, dn);
        check("R8 erase total cycles", cnt, ERS_C - p1);
        check("R4 erase done", int'(dn), 1);
        do_read(1, 1'b0, 2, d);
        check("R7 array after erase", int'(d), int'(ARR));

        // R6: partial protection, sector 4 protected, 5 not
        send(3'd2, 0, 8'h30, 8'h10);
        do_read(4, 1'b0, 2, d);
        exp6 = ~exp6;
        check("R6 protected sector no dq2", int'(d), int'(stat_word()));
        do_read(5, 1'b0, 2, d);
        exp6 = ~exp6; exp2 = ~exp2;
        check("R6 unprotected sector dq2", int'(d), int'(stat_word()));
        send(3'd5, 0, 8'h00, 8'h00);
        check("R10 reset cmd ready", int'(rdy), 1);
        check("R10 reset cmd no done", int'(op_done), 0);

        // R6: all protected, sector 7
        send(3'd2, 0, 8'h80, 8'h80);
        do_read(7, 1'b1, 2, d);
        exp6 = ~exp6; exp2 = ~exp2;
        check("R6 all protected dq2", int'(d), int'(stat_word()));
        send(3'd5, 0, 8'h00, 8'h00);
        do_read(7, 1'b0, 2, d);
        check("R10 array after reset cmd", int'(d), int'(ARR));

        // R10: ignored commands
        send(3'd3, 0, 8'h00, 8'h00);
        check("R10 suspend in idle ignored", int'(rdy), 1);
        send(3'd4, 0, 8'h00, 8'h00);
        check("R10 resume in idle ignored", int'(rdy), 1);
        send(3'd2, 0, 8'h00, 8'h00);
        check("R10 empty erase ignored", int'(rdy), 1);
        do_read(0, 1'b0, 2, d);
        check("R10 R1 idle read", int'(d), int'(ARR));
        send(3'd1, 0, 8'h00, 8'h00);
        t0 = ncyc;
        tick(); tick();
        send(3'd1, 0, 8'h00, 8'h00);
        wait_ready(PGM_C + 20, cnt, dn);
        check("R10 program restart ignored", ncyc - t0, PGM_C);

        // R1: reset during erase
        send(3'd2, 0, 8'h01, 8'h00);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check("R1 reset clears busy", int'(rdy), 1);
        exp6 = 1'b0; exp2 = 1'b0;
        send(3'd1, 0, 8'h00, 8'h00);
        do_read(0, 1'b0, 2, d);
        exp6 = ~exp6;
        check("R1 toggles reset to zero", int'(d), int'(stat_word()));
        wait_ready(PGM_C + 5, cnt, dn);

        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule